// File: doc/BRIEF.md
# Synchronous Serial Port Master with Transmit and Receive FIFOs

This block is a serial peripheral master that software drives through five word-aligned registers. Software sets the frame length, clock idle level, sampling edge and bit rate, writes frames into an eight-entry transmit FIFO, and reads the matching received frames back from an eight-entry receive FIFO. A status word gives FIFO occupancy flags and a busy flag. The block does not expose the shifter itself.

When the port is enabled and the transmit FIFO holds data, the block lowers the chip select and shifts frames most significant bit first. Consecutive frames follow each other with the chip select held low. Each frame sends one word on the serial output and captures one word from the serial input. The bit clock comes from two dividers in series: an even prescaler, and then a rate factor of one plus an eight-bit value. Frame lengths from 1 to 16 bits and all four clock polarity and phase combinations are supported.

Top module: `ssp_master`

## Requirements
- R1: After reset, the registers read back as follows: control 0 = 0, control 1 = 0, prescale = 2, status = 0x0003. The chip select output is high and the serial clock output is low.
- R2: Register word offsets are: control 0 at 0x00, control 1 at 0x04, data at 0x08, status at 0x0C, prescale at 0x10. Control 0 reads back exactly as written. Its fields are: bits 3:0 hold the frame length minus one, bit 6 is the clock idle level, bit 7 selects the sampling edge, and bits 15:8 hold the rate factor.
- R3: Control 1 bit 1 enables the port. While it is clear, no frame starts, the chip select stays high, and queued transmit data is kept. Clearing it during a frame abandons that frame: the chip select goes high and no received word is stored.
- R4: Every serial clock half period lasts (prescale/2)·(1+rate factor) input clock cycles. This includes the interval from the chip select falling to the first edge, and the interval from the last edge of one frame to the first edge of the next.
- R5: The prescale register holds an even value from 2 to 254. A write stores bits 7:1 of the data with bit 0 cleared. A write whose stored result would be 0 is ignored.
- R6: Frames are sent most significant bit first, starting at bit (length−1). When the port is not shifting, the serial clock rests at the idle level. With bit 7 clear, the input is sampled on the first edge of each bit period and the output changes on the second. With bit 7 set, the output changes on the first edge and the input is sampled on the second.
- R7: The chip select stays low across back-to-back frames while the transmit FIFO still holds data. It rises in the cycle of the final clock edge of the last frame.
- R8: Each transmitted frame places exactly one word in the receive FIFO. The received bits are right-aligned, and the bits above the frame length read as zero.
- R9: The status word has the following bits: bit 0 set when the transmit FIFO is empty, bit 1 set when it is not full, bit 2 set when the receive FIFO is not empty, bit 3 set when it is full, and bit 4 busy. Bits 15:5 read zero.
- R10: A data write while the transmit FIFO already holds eight words is dropped.
- R11: A data read from an empty receive FIFO returns zero and leaves the FIFO unchanged. A frame that completes while the receive FIFO is full is discarded, and the stored words are kept.
- R12: Busy is set while a frame is shifting or while the transmit FIFO holds data. When busy is clear, the chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Register write strobe, one cycle per write |
| busRd | input | 1 | Register read strobe; on the data register it pops the receive FIFO |
| busAddr | input | 5 | Register byte address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCsN | output | 1 | Chip select, active low |

## Verification
The serial function is run with four settings: 8-bit mode 0, 12-bit mode 3 at the fastest rate, 16-bit with phase set and a divided clock, and 5-bit with a high idle level and a rate factor above zero. These settings separate the two sampling edges, the effect of the idle level, the frame-length mask, and the product of the two divider stages. A slave model in the bench changes its input on the transmit edges. If the block sampled on the wrong edge, the received words would shift by one bit. Burst tests fill the transmit FIFO past its depth and the receive FIFO to its limit, which exercises the drop rules. A final test abandons a slow frame to check the enable.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned SIZE_W     = $clog2(DATA_W);
  localparam int unsigned PRESC_W    = 8;
  localparam int unsigned RATE_W     = 8;

  // register word index (byte address bits 4:2)
  localparam logic [2:0] REG_CTRL0 = 3'd0;
  localparam logic [2:0] REG_CTRL1 = 3'd1;
  localparam logic [2:0] REG_DATA  = 3'd2;
  localparam logic [2:0] REG_STAT  = 3'd3;
  localparam logic [2:0] REG_PRESC = 3'd4;

  typedef struct packed {
    logic               en;
    logic               pol;
    logic               pha;
    logic [SIZE_W-1:0]  sizeM1;
    logic [RATE_W-1:0]  rate;
    logic [PRESC_W-1:0] presc;
  } sspCfg_t;

  typedef struct packed {
    logic load;    // pop transmit FIFO into the shifter
    logic sample;  // capture the serial input
    logic shift;   // advance the serial output
    logic push;    // frame complete, store received word
  } sspStrobe_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign popData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  sspCfg_t    cfg,
  input  logic       txEmpty,
  output sspStrobe_t strobe,
  output logic       sclk,
  output logic       csN,
  output logic       active
);
  localparam int unsigned DIV_W  = PRESC_W + RATE_W;
  localparam int unsigned EDGE_W = $clog2(2 * DW) + 1;

  typedef enum logic {S_IDLE, S_SHIFT} state_t;
  state_t state;

  logic [DIV_W-1:0]  halfPer, divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              phase, tick, lastEdge, startOk;

  assign halfPer  = DIV_W'(cfg.presc[PRESC_W-1:1]) * (DIV_W'(cfg.rate) + DIV_W'(1));
  assign tick     = (state == S_SHIFT) && cfg.en && (divCnt == halfPer - DIV_W'(1));
  assign lastEdge = (edgeCnt == EDGE_W'({cfg.sizeM1, 1'b1}));
  assign startOk  = cfg.en && !txEmpty;

  always_comb begin
    strobe.load   = startOk && ((state == S_IDLE) || (tick && lastEdge));
    strobe.sample = tick && (edgeCnt[0] == cfg.pha);
    strobe.shift  = tick && (edgeCnt[0] != cfg.pha) && (edgeCnt != '0) && !lastEdge;
    strobe.push   = tick && lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
      csN     <= 1'b1;
    end else if (!cfg.en) begin
      state   <= S_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
      csN     <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (strobe.load) begin
          state   <= S_SHIFT;
          csN     <= 1'b0;
          divCnt  <= '0;
          edgeCnt <= '0;
          phase   <= 1'b0;
        end
        S_SHIFT: if (tick) begin
          divCnt <= '0;
          if (lastEdge) begin
            phase   <= 1'b0;
            edgeCnt <= '0;
            if (!strobe.load) begin
              state <= S_IDLE;
              csN   <= 1'b1;
            end
          end else begin
            phase   <= ~phase;
            edgeCnt <= edgeCnt + EDGE_W'(1);
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sclk   = cfg.pol ^ phase;
  assign active = (state == S_SHIFT);
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [AW-1:0] busAddr,
  input  logic [15:0]   busWdata,
  output logic [15:0]   busRdata,
  input  sspStrobe_t    strobe,
  input  logic          active,
  input  logic          miso,
  output logic          mosi,
  output sspCfg_t       cfg,
  output logic          txEmpty,
  output logic          txFull,
  output logic          rxEmpty,
  output logic          rxFull,
  output logic          busy
);
  logic [15:0]        ctrl0;
  logic               enReg;
  logic [PRESC_W-1:0] prescReg;
  logic [2:0]         regIdx;
  logic               addrOk;
  logic [DW-1:0]      txHead, rxHead, txShift, rxShift, rxNext, frameMask;

  assign regIdx = busAddr[AW-1:2];
  assign addrOk = (busAddr[1:0] == 2'b00);

  assign cfg.en     = enReg;
  assign cfg.pol    = ctrl0[6];
  assign cfg.pha    = ctrl0[7];
  assign cfg.sizeM1 = ctrl0[SIZE_W-1:0];
  assign cfg.rate   = ctrl0[15:8];
  assign cfg.presc  = prescReg;

  // bits above the frame length are cleared in received words
  for (genvar g = 0; g < DW; g++) begin : gMask
    assign frameMask[g] = (g <= int'(cfg.sizeM1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl0    <= '0;
      enReg    <= 1'b0;
      prescReg <= PRESC_W'(2);
    end else if (busWr && addrOk) begin
      case (regIdx)
        REG_CTRL0: ctrl0 <= busWdata;
        REG_CTRL1: enReg <= busWdata[1];
        REG_PRESC: if (busWdata[PRESC_W-1:1] != '0) prescReg <= {busWdata[PRESC_W-1:1], 1'b0};
        default: ;
      endcase
    end
  end

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(busWr && addrOk && regIdx == REG_DATA), .pushData(busWdata[DW-1:0]),
    .pop(strobe.load), .popData(txHead),
    .empty(txEmpty), .full(txFull)
  );

  assign rxNext = {rxShift[DW-2:0], miso};

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.push), .pushData((strobe.sample ? rxNext : rxShift) & frameMask),
    .pop(busRd && addrOk && regIdx == REG_DATA), .popData(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.load)       txShift <= txHead;
      else if (strobe.shift) txShift <= txShift << 1;
      if (strobe.load)        rxShift <= '0;
      else if (strobe.sample) rxShift <= rxNext;
    end
  end

  assign mosi = txShift[cfg.sizeM1];
  assign busy = active || !txEmpty;

  always_comb begin
    busRdata = '0;
    if (addrOk) begin
      case (regIdx)
        REG_CTRL0: busRdata = ctrl0;
        REG_CTRL1: busRdata = {14'd0, enReg, 1'b0};
        REG_DATA:  busRdata = rxEmpty ? 16'd0 : 16'(rxHead);
        REG_STAT:  busRdata = {11'd0, busy, rxFull, !rxEmpty, !txFull, txEmpty};
        REG_PRESC: busRdata = 16'(prescReg);
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [4:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic        spiCsN
);
  sspCfg_t    cfg;
  sspStrobe_t strobe;
  logic       active, txEmpty, txFull, rxEmpty, rxFull, busy;

  ssp_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .txEmpty(txEmpty),
    .strobe(strobe), .sclk(spiSclk), .csN(spiCsN), .active(active)
  );

  ssp_datapath #(.DW(DATA_W), .DEPTH(FIFO_DEPTH), .AW(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe), .active(active),
    .miso(spiMiso), .mosi(spiMosi), .cfg(cfg), .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .busy(busy)
  );
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic        busRd,
  input logic [4:0]  busAddr,
  input logic [15:0] busRdata,
  input logic        spiSclk,
  input logic        spiCsN,
  input logic        busy,
  input logic        txEmpty,
  input logic        txFull,
  input logic        rxEmpty,
  input logic        rxFull
);
  a_r12_idle_deselect: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

  a_r12_busy_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> txEmpty);

  a_r6_clock_rests: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN && $past(spiCsN) && !$past(busWr)) |-> $stable(spiSclk));

  a_r11_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rxEmpty && busRd && busAddr == 5'h08) |-> (busRdata == 16'd0));

  a_r9_flag_pairs: assert property (@(posedge clk) disable iff (!rstN)
    !(txEmpty && txFull) && !(rxEmpty && rxFull));

  a_r7_select_needs_work: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> busy);
endmodule

bind ssp_master ssp_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busRdata(busRdata), .spiSclk(spiSclk), .spiCsN(spiCsN), .busy(busy),
  .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull)
);

// File: tb/ssp_master_tb.sv
module ssp_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;
  localparam logic [4:0] A_CTRL0 = 5'h00, A_CTRL1 = 5'h04, A_DATA = 5'h08,
                         A_STAT = 5'h0C, A_PRESC = 5'h10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [4:0] busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic spiSclk, spiMosi, spiCsN;
  logic spiMiso = 1'b0;

  ssp_master u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  int cfgBits = 1, cfgPha = 0, cfgHalf = 1;
  int sentIdx = 0, csRises = 0;
  logic [15:0] expTx[$], expRx[$], capQ[$];

  task automatic check(string req, string what, int got, int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] slaveWord(int i);
    return 16'((i * 32'h1357) ^ 32'hA5C3);
  endfunction

  function automatic logic [15:0] maskOf(int bits);
    return 16'((32'd1 << bits) - 1);
  endfunction

  // reference slave: tracks edges, drives input, captures output
  int edgeIdx = 0, frameNo = 0, gap = 0;
  logic prevCs = 1'b1, prevSclk = 1'b0, prevMosi = 1'b0;
  logic [15:0] capWord = '0;
  always @(negedge clk) begin
    if (rstN) begin
      int bitIdx;
      logic [15:0] sw;
      gap++;
      if (prevCs && !spiCsN) gap = 0;
      if (!prevCs && spiCsN) csRises++;
      if (!prevCs && (spiSclk != prevSclk)) begin
        check("R4", "half period", gap, cfgHalf);
        gap = 0;
        if ((edgeIdx % 2) == cfgPha) capWord = {capWord[14:0], prevMosi};
        edgeIdx++;
        if (edgeIdx == 2 * cfgBits) begin
          capQ.push_back(capWord & maskOf(cfgBits));
          capWord = '0;
          edgeIdx = 0;
          frameNo++;
        end
      end
      bitIdx = cfgPha ? ((edgeIdx == 0) ? 0 : (edgeIdx - 1) / 2) : edgeIdx / 2;
      sw = slaveWord(frameNo);
      spiMiso = sw[cfgBits - 1 - bitIdx];
      prevCs = spiCsN;
      prevSclk = spiSclk;
      prevMosi = spiMosi;
    end
  end

  task automatic busWrite(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic setMode(int bits, int pol, int pha, int rate, int presc);
    busWrite(A_CTRL0, 16'((rate << 8) | (pha << 7) | (pol << 6) | (bits - 1)));
    busWrite(A_PRESC, 16'(presc));
    cfgBits = bits; cfgPha = pha; cfgHalf = (presc / 2) * (rate + 1);
  endtask

  task automatic sendWord(logic [15:0] w, bit expectStored);
    busWrite(A_DATA, w);
    expTx.push_back(w & maskOf(cfgBits));
    if (expectStored) expRx.push_back(slaveWord(sentIdx) & maskOf(cfgBits));
    sentIdx++;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    do busRead(A_STAT, s); while (s[4]);
    repeat (3) @(negedge clk);
  endtask

  task automatic drainAndCompare(string tag);
    logic [15:0] v;
    while (expRx.size() > 0) begin
      busRead(A_DATA, v);
      check("R8", {tag, " received word"}, v, expRx.pop_front());
    end
    check("R6", {tag, " frame count"}, capQ.size(), expTx.size());
    while (expTx.size() > 0 && capQ.size() > 0)
      check("R6", {tag, " shifted word"}, capQ.pop_front(), expTx.pop_front());
    expTx.delete();
    capQ.delete();
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL R12 watchdog expired: got 0x1 expected 0x0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int rises;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "chip select", spiCsN, 1);
    check("R1", "serial clock", spiSclk, 0);
    busRead(A_CTRL0, v); check("R1", "control 0", v, 16'h0000);
    busRead(A_CTRL1, v); check("R1", "control 1", v, 16'h0000);
    busRead(A_PRESC, v); check("R1", "prescale", v, 16'h0002);
    busRead(A_STAT, v);  check("R9", "status after reset", v, 16'h0003);

    // R2 control 0 readback, R5 prescale rules
    busWrite(A_CTRL0, 16'h12F3); busRead(A_CTRL0, v); check("R2", "control 0 readback", v, 16'h12F3);
    busWrite(A_PRESC, 16'h0007); busRead(A_PRESC, v); check("R5", "odd prescale", v, 16'h0006);
    busWrite(A_PRESC, 16'h0001); busRead(A_PRESC, v); check("R5", "prescale below 2 ignored", v, 16'h0006);
    busWrite(A_PRESC, 16'h00FE); busRead(A_PRESC, v); check("R5", "max prescale", v, 16'h00FE);

    // mode 0, 8 bit, half period 4; R3 queued while disabled
    setMode(8, 0, 0, 1, 4);
    sendWord(16'h00C3, 1); sendWord(16'h005A, 1); sendWord(16'h0081, 1);
    repeat (40) @(negedge clk);
    check("R3", "chip select while disabled", spiCsN, 1);
    busRead(A_STAT, v); check("R12", "busy with queued data", v, 16'h0012);
    rises = csRises;
    busWrite(A_CTRL1, 16'h0002);
    waitIdle();
    check("R7", "one deselect for burst", csRises - rises, 1);
    busRead(A_STAT, v); check("R9", "status after burst", v, 16'h0007);
    drainAndCompare("mode0-8");

    // mode 3, 12 bit, fastest rate
    busWrite(A_CTRL1, 16'h0000);
    setMode(12, 1, 1, 0, 2);
    repeat (2) @(negedge clk);
    check("R6", "idle level high", spiSclk, 1);
    sendWord(16'h0ABC, 1); sendWord(16'hF123, 1);
    busWrite(A_CTRL1, 16'h0002);
    waitIdle();
    drainAndCompare("mode3-12");

    // phase set, 16 bit, half period 9
    busWrite(A_CTRL1, 16'h0000);
    setMode(16, 0, 1, 2, 6);
    sendWord(16'h8001, 1); sendWord(16'h7E5D, 1);
    busWrite(A_CTRL1, 16'h0002);
    waitIdle();
    drainAndCompare("mode1-16");

    // idle high, phase clear, 5 bit, half period 4
    busWrite(A_CTRL1, 16'h0000);
    setMode(5, 1, 0, 3, 2);
    sendWord(16'hFFF5, 1); sendWord(16'h000A, 1);
    busWrite(A_CTRL1, 16'h0002);
    waitIdle();
    drainAndCompare("mode2-5");

    // R10 transmit overflow, R11 receive overflow
    busWrite(A_CTRL1, 16'h0000);
    setMode(8, 0, 0, 0, 2);
    for (int i = 0; i < 8; i++) sendWord(16'(8'h11 * (i + 1)), 1);
    busWrite(A_DATA, 16'h00EE);   // ninth write, dropped
    busRead(A_STAT, v); check("R10", "transmit full status", v, 16'h0010);
    busWrite(A_CTRL1, 16'h0002);
    waitIdle();
    busRead(A_STAT, v); check("R9", "receive full status", v, 16'h000F);
    sendWord(16'h0066, 0);        // completes into a full receive FIFO
    waitIdle();
    busRead(A_STAT, v); check("R11", "full receive kept", v, 16'h000F);
    drainAndCompare("overflow");
    busRead(A_STAT, v); check("R9", "drained status", v, 16'h0003);
    busRead(A_DATA, v); check("R11", "empty read value", v, 16'h0000);
    busRead(A_STAT, v); check("R11", "empty read no change", v, 16'h0003);

    // R3 abandon a slow frame
    busWrite(A_CTRL1, 16'h0000);
    setMode(8, 0, 0, 255, 254);
    busWrite(A_DATA, 16'h0042);
    busWrite(A_CTRL1, 16'h0002);
    repeat (20) @(negedge clk);
    check("R3", "frame started", spiCsN, 0);
    busWrite(A_CTRL1, 16'h0000);
    @(negedge clk);
    check("R3", "chip select after abort", spiCsN, 1);
    busRead(A_STAT, v); check("R3", "no word stored after abort", v, 16'h0003);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule